// File: doc/BRIEF.md
# Decade Counter with Seven-Segment Drive

This block counts rising edges of a slow count clock from 0 through 9 and wraps back to 0. The current digit drives active-high segment outputs for a common-cathode seven-segment display. The count clock is sampled by the system clock through a synchronizer, so the count clock may be asynchronous to the system clock. Its rising edges are found by comparing successive synchronized samples.

A clear input forces the count to zero and a hold input freezes it. A display enable input blanks all segments, and a registered copy of it is brought out one system clock later. Two flags decode the count directly. The first is a symmetric divide-by-ten output, which is high for the lower five digits; to build several digits, it drives the count clock of the next stage. The second is low only at digit two.

Top module: `decade_seg_counter`

## Requirements
- R1: Each 0-to-1 transition of `cnt_clk_i` advances the count by one, wrapping from 9 to 0. The new count appears at the outputs three system-clock edges after the transition is first sampled. A steady high level does not count again.
- R2: While `clr_i` is high, the count becomes 0 at the next system-clock edge. Clear takes priority over hold and over counting.
- R3: While `hold_i` is high and `clr_i` is low, count-clock edges are ignored and the count stays unchanged. An edge seen during hold is not counted after hold is released.
- R4: With `disp_en_i` high, `seg_o` (bit 0 = a through bit 6 = g) shows the digit as follows: 0=0x3F, 1=0x06, 2=0x5B, 3=0x4F, 4=0x66, 5=0x6D, 6=0x7D, 7=0x07, 8=0x7F, 9=0x6F.
- R5: With `disp_en_i` low, `seg_o` is 0 whatever the count, and the count is not affected.
- R6: `en_out_o` equals the value `disp_en_i` had at the previous system-clock edge.
- R7: `div10_o` is high for counts 0 to 4 and low for counts 5 to 9.
- R8: `not_two_o` is low when the count is 2 and high for every other count.
- R9: While `rst_ni` is low, the count is 0 and `en_out_o` is 0, independent of the clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cnt_clk_i | input | 1 | Count clock, may be asynchronous |
| clr_i | input | 1 | Synchronous clear of the count, active high |
| hold_i | input | 1 | Ignore count-clock edges while high |
| disp_en_i | input | 1 | Display enable; low blanks the segments |
| seg_o | output | 7 | Segments a (bit 0) to g (bit 6), active high |
| div10_o | output | 1 | High for counts 0 to 4 |
| not_two_o | output | 1 | Low only at count 2 |
| en_out_o | output | 1 | `disp_en_i` delayed by one system clock |

## Verification
The count clock is pulsed through three full wraps. At every digit, the segment pattern, the divide-by-ten level and the not-two flag are compared with their expected values, which shows whether the decode is correct and whether the 9-to-0 wrap is clean. Long high levels on the count clock separate true edge detection from level counting. Pulses applied during hold, both with and without a simultaneous clear, show the priority order and whether an edge leaks through after hold is released. Toggling display enable at a mid-range digit separates blanking from count corruption and checks the one-cycle delay of the echo output.

// File: rtl/dsc_pkg.sv
package dsc_pkg;
  localparam int unsigned SEG_W = 7;
  typedef logic [SEG_W-1:0] seg_t;
endpackage

// File: rtl/dsc_edge_det.sv
module dsc_edge_det #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic rise_o
);
  logic [STAGES:0] sh_q;

  for (genvar i = 0; i <= STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[0] <= 1'b0;
        else         sh_q[0] <= d_i;
    end else begin : g_rest
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni) sh_q[i] <= 1'b0;
        else         sh_q[i] <= sh_q[i-1];
    end
  end

  // last stage holds the previous synchronized sample
  assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];

  AST_RISE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rise_o |=> !rise_o); // R1
endmodule

// File: rtl/dsc_counter.sv
module dsc_counter #(
  parameter int unsigned MAX_CNT = 9,
  localparam int unsigned CNT_W = $clog2(MAX_CNT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             step_i,
  input  logic             clr_i,
  input  logic             hold_i,
  output logic [CNT_W-1:0] cnt_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)                     cnt_d = '0;
    else if (hold_i)               cnt_d = cnt_q;
    else if (step_i)               cnt_d = (cnt_q == CNT_W'(MAX_CNT)) ? '0 : cnt_q + 1'b1;
  end

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_d;

  assign cnt_o = cnt_q;

  AST_CNT_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_CNT)); // R1
  AST_WRAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i && !clr_i && !hold_i && cnt_q == CNT_W'(MAX_CNT) |=> cnt_q == '0); // R1
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> cnt_q == '0); // R2
  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_i && !clr_i |=> $stable(cnt_q)); // R3
endmodule

// File: rtl/dsc_seg_dec.sv
module dsc_seg_dec
  import dsc_pkg::*;
#(
  parameter int unsigned CNT_W = 4
) (
  input  logic [CNT_W-1:0] digit_i,
  input  logic             en_i,
  output seg_t             seg_o
);
  seg_t raw;

  always_comb begin
    unique case (digit_i)
      CNT_W'(0): raw = 7'h3F;
      CNT_W'(1): raw = 7'h06;
      CNT_W'(2): raw = 7'h5B;
      CNT_W'(3): raw = 7'h4F;
      CNT_W'(4): raw = 7'h66;
      CNT_W'(5): raw = 7'h6D;
      CNT_W'(6): raw = 7'h7D; // tail on a
      CNT_W'(7): raw = 7'h07;
      CNT_W'(8): raw = 7'h7F;
      CNT_W'(9): raw = 7'h6F; // tail on d
      default:   raw = '0;
    endcase
  end

  assign seg_o = en_i ? raw : '0;

  always_comb begin
    AST_BLANK_ZERO: assert (en_i || seg_o == '0); // R5
  end
endmodule

// File: rtl/decade_seg_counter.sv
module decade_seg_counter
  import dsc_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned MAX_CNT     = 9,
  localparam int unsigned CNT_W      = $clog2(MAX_CNT + 1),
  localparam int unsigned HALF       = (MAX_CNT + 1) / 2
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       cnt_clk_i,
  input  logic       clr_i,
  input  logic       hold_i,
  input  logic       disp_en_i,
  output logic [6:0] seg_o,
  output logic       div10_o,
  output logic       not_two_o,
  output logic       en_out_o
);
  logic             rise;
  logic [CNT_W-1:0] cnt;
  seg_t             seg;
  logic             en_q;

  dsc_edge_det #(.STAGES(SYNC_STAGES)) i_edge (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   (cnt_clk_i),
    .rise_o(rise)
  );

  dsc_counter #(.MAX_CNT(MAX_CNT)) i_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .step_i(rise),
    .clr_i (clr_i),
    .hold_i(hold_i),
    .cnt_o (cnt)
  );

  dsc_seg_dec #(.CNT_W(CNT_W)) i_dec (
    .digit_i(cnt),
    .en_i   (disp_en_i),
    .seg_o  (seg)
  );

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) en_q <= 1'b0;
    else         en_q <= disp_en_i;

  assign seg_o     = seg;
  assign div10_o   = (cnt < CNT_W'(HALF));
  assign not_two_o = (cnt != CNT_W'(2));
  assign en_out_o  = en_q;

  AST_EN_ECHO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> en_out_o == $past(disp_en_i)); // R6
  AST_DIV_FALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(div10_o) |-> cnt == CNT_W'(HALF)); // R7
  AST_NOT_TWO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !not_two_o |-> !seg_o[2] || !disp_en_i); // R8
endmodule

// File: tb/test_decade_seg_counter.sv
module test_decade_seg_counter;
  logic clk = 0, rst_n = 0, cnt_clk = 0, clr = 0, hold = 0, den = 1;
  logic [6:0] seg;
  logic div10, not_two, en_out;
  int checks = 0, fails = 0, exp_cnt = 0;
  bit done = 0;

  decade_seg_counter i_decade_seg_counter (
    .clk_i(clk), .rst_ni(rst_n), .cnt_clk_i(cnt_clk), .clr_i(clr), .hold_i(hold),
    .disp_en_i(den), .seg_o(seg), .div10_o(div10), .not_two_o(not_two), .en_out_o(en_out)
  );

  always #5 clk = ~clk;

  function automatic logic [6:0] pat(int d);
    case (d)
      0: return 7'h3F; 1: return 7'h06; 2: return 7'h5B; 3: return 7'h4F; 4: return 7'h66;
      5: return 7'h6D; 6: return 7'h7D; 7: return 7'h07; 8: return 7'h7F; default: return 7'h6F;
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic pulse(int hi_len);
    @(negedge clk) cnt_clk = 1;
    repeat (hi_len) @(negedge clk);
    cnt_clk = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic check_digit(string req);
    chk({req, "_R4_seg"}, seg, pat(exp_cnt));
    chk("R7_div10", div10, exp_cnt < 5);
    chk("R8_not_two", not_two, exp_cnt != 2);
  endtask

  task automatic t_reset;
    #2;
    chk("R9_seg", seg, 7'h3F);
    chk("R9_en_out", en_out, 0);
    @(negedge clk) rst_n = 1;
    @(negedge clk);
    chk("R6_after_reset", en_out, 1);
  endtask

  task automatic t_sweep;
    for (int i = 0; i < 30; i++) begin
      pulse((i % 3 == 0) ? 12 : 4); // long high must count once, R1
      exp_cnt = (exp_cnt + 1) % 10;
      check_digit("R1");
    end
  endtask

  task automatic t_hold;
    hold = 1;
    pulse(4); pulse(6);
    check_digit("R3_held");
    hold = 0;
    repeat (6) @(negedge clk);
    check_digit("R3_released");
    pulse(4);
    exp_cnt = (exp_cnt + 1) % 10;
    check_digit("R3_resume");
  endtask

  task automatic t_clear;
    while (exp_cnt != 7) begin pulse(4); exp_cnt = (exp_cnt + 1) % 10; end
    @(negedge clk) begin clr = 1; hold = 1; end
    @(negedge clk) begin clr = 0; hold = 0; end
    exp_cnt = 0;
    check_digit("R2_over_hold");
    pulse(4); pulse(4);
    clr = 1;
    pulse(4);
    clr = 0;
    exp_cnt = 0;
    check_digit("R2_over_count");
  endtask

  task automatic t_blank;
    while (exp_cnt != 5) begin pulse(4); exp_cnt = (exp_cnt + 1) % 10; end
    @(negedge clk) den = 0;
    #1 chk("R5_blank", seg, 0);
    chk("R6_not_yet", en_out, 1);
    @(negedge clk);
    chk("R6_echo_low", en_out, 0);
    pulse(4);
    exp_cnt = 6;
    chk("R5_blank_count", seg, 0);
    chk("R7_blanked", div10, 0);
    @(negedge clk) den = 1;
    #1 check_digit("R5_restore");
    @(negedge clk);
    chk("R6_echo_high", en_out, 1);
  endtask

  initial begin
    t_reset();
    t_sweep();
    t_hold();
    t_clear();
    t_blank();
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog act=hung exp=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule